// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block sits between a clocked host and an asynchronous 32K x 8 static RAM. The host asks for one access at a time with a single-cycle request that carries a read/write flag, a 15-bit address and a byte of write data. The controller then drives the memory's active-low chip enable, write enable and output enable. It also drives the address and a split data bus with separate in, out and drive-enable signals. When the access is over it raises a one-cycle acknowledge, and for reads the captured byte appears on the same cycle.

The number of clock cycles for each strobe interval is fixed when the design is elaborated. Each nanosecond limit is divided by the clock period and rounded up to whole cycles. The limits are read cycle, access time, output float time, write cycle, write pulse, chip-enable-to-end-of-write and data setup. Writes are controlled by the write-enable pulse, and output enable stays high for the whole write. The data bus is not driven until the float-time gap has passed, so the controller never drives against memory outputs that are still active. With the default 10 ns clock, a read holds its strobes for 7 cycles. A write holds chip enable for 7 cycles, holds write enable low for 6 of them, and drives data from the 4th through the 7th.

Top module: `sram_timing_ctrl`

## Requirements
- R1: After reset, and in every cycle with no access in progress, chip enable, write enable and output enable are high (1), the data drive enable is low (0) and ack is low.
- R2: A request is accepted only at a clock edge where the controller is idle. A request raised while an access is running is ignored: the strobe sequence, address and ack of the running access are unchanged, and no further access follows.
- R3: A read accepted at edge k holds chip enable low, output enable low and write enable high for the 7 cycles after edge k (the read cycle time rounded up to clock periods). The address equals the requested address throughout those cycles.
- R4: Read data is captured from the memory data input at the edge that ends the 7th strobe cycle (the access time rounded up) and not earlier. It is presented on rdata in the ack cycle.
- R5: A write holds chip enable low, and holds write enable low for the first 6 of its strobe cycles. This is at least the 35 ns pulse and at least 45 ns of chip enable before write enable rises. Output enable stays high in every write cycle.
- R6: During the first 3 cycles of a write (the 30 ns float time rounded up) the data drive enable is low.
- R7: Write data is driven for the 3 cycles before write enable rises, which meets the 30 ns setup. Driving continues in the one cycle after write enable rises and ends on the cycle after that.
- R8: A write keeps chip enable low for 7 cycles in total (the write cycle time), after which the memory holds the written byte at the requested address.
- R9: Ack is high for exactly one cycle, directly after the last strobe cycle of each access, with chip enable already high.
- R10: The data drive enable is never high while chip enable and output enable are both low, and never within 3 cycles after they stop being both low.
- R11: A request raised in the ack cycle is accepted at the next edge, so accesses can run back to back with one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Single-cycle access request |
| wr | input | 1 | 1 = write, 0 = read; sampled with req |
| addr | input | 15 | Access address; sampled with req |
| wdata | input | 8 | Write byte; sampled with req |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read byte, valid with ack |
| sram_addr | output | 15 | Memory address |
| sram_dq_out | output | 8 | Data toward the memory |
| sram_dq_in | input | 8 | Data from the memory |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |

## Verification
Two things can fall in the same cycle: the ack that ends one access, and the acceptance of the next request. The bench raises each new request in the very cycle it sees ack, so read-after-write and write-after-read run back to back. Every clock, it compares the strobe pattern against a queue of expected per-cycle values. The bench's memory model also times, cycle by cycle, how long the outputs have been floating. Any drive enable that falls inside the float window after a read counts as contention. The model returns inverted data until the access count has elapsed, so a capture made too early shows up as a wrong rdata.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } ctl_state_e;

    // Round a nanosecond limit up to whole clock cycles; zero stays zero.
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        if (ns <= 0) return 0;
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int RD_LAST = 6,
    parameter int AA_IDX  = 6,
    parameter int W_LAST  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             wr,
    output ctl_state_e       st_d_o,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic             accept,
    output logic             capture,
    output logic             ack
);

    localparam logic [CNT_W-1:0] RD_LAST_C = CNT_W'(RD_LAST);
    localparam logic [CNT_W-1:0] AA_IDX_C  = CNT_W'(AA_IDX);
    localparam logic [CNT_W-1:0] W_LAST_C  = CNT_W'(W_LAST);

    typedef struct packed {
        ctl_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             ack;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.ack = 1'b0;
        accept  = 1'b0;
        capture = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req) begin
                    accept  = 1'b1;
                    s_d.st  = wr ? ST_WRITE : ST_READ;
                    s_d.cnt = '0;
                end
            end
            ST_READ: begin
                capture = (s_q.cnt == AA_IDX_C);
                if (s_q.cnt == RD_LAST_C) begin
                    s_d.st  = ST_IDLE;
                    s_d.cnt = '0;
                    s_d.ack = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_WRITE: begin
                if (s_q.cnt == W_LAST_C) begin
                    s_d.st  = ST_IDLE;
                    s_d.cnt = '0;
                    s_d.ack = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: begin
                s_d.st  = ST_IDLE;
                s_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cnt: '0, ack: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign st_d_o  = s_d.st;
    assign cnt_d_o = s_d.cnt;
    assign ack     = s_q.ack;

endmodule

// File: rtl/sram_ctrl_strobe.sv
module sram_ctrl_strobe
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int HZ_GAP = 3,
    parameter int W_LOW  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_state_e       st_d,
    input  logic [CNT_W-1:0] cnt_d,
    output logic             ce_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             drv
);

    localparam logic [CNT_W-1:0] HZ_GAP_C = CNT_W'(HZ_GAP);
    localparam logic [CNT_W-1:0] W_LOW_C  = CNT_W'(W_LOW);

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic drv;
    } strobe_t;

    localparam strobe_t IDLE_PINS = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

    strobe_t p_d, p_q;

    // Pins are decoded from the next state so that every strobe leaves a flop.
    always_comb begin
        p_d = IDLE_PINS;
        unique case (st_d)
            ST_READ: begin
                p_d.ce_n = 1'b0;
                p_d.oe_n = 1'b0;
            end
            ST_WRITE: begin
                p_d.ce_n = 1'b0;
                p_d.we_n = (cnt_d >= W_LOW_C);
                p_d.drv  = (cnt_d >= HZ_GAP_C) && (cnt_d <= W_LOW_C);
            end
            default: p_d = IDLE_PINS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= IDLE_PINS;
        end else begin
            p_q <= p_d;
        end
    end

    assign ce_n = p_q.ce_n;
    assign we_n = p_q.we_n;
    assign oe_n = p_q.oe_n;
    assign drv  = p_q.drv;

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdat;
        logic [DATA_W-1:0] rdat;
    } dp_t;

    dp_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        if (accept) begin
            d_d.addr = addr;
            d_d.wdat = wdata;
        end
        if (capture) begin
            d_d.rdat = dq_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign mem_addr = d_q.addr;
    assign dq_out   = d_q.wdat;
    assign rdata    = d_q.rdat;

endmodule

// File: rtl/sram_timing_ctrl.sv
module sram_timing_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 10,
    parameter int T_RC_NS  = 70,
    parameter int T_AA_NS  = 70,
    parameter int T_HZ_NS  = 30,
    parameter int T_WC_NS  = 70,
    parameter int T_WP_NS  = 35,
    parameter int T_CW_NS  = 45,
    parameter int T_DW_NS  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_dq_oe,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n
);

    localparam int C_RC  = ns_to_cycles(T_RC_NS, CLK_NS);
    localparam int C_AA  = max2(ns_to_cycles(T_AA_NS, CLK_NS), 1);
    localparam int C_HZ  = ns_to_cycles(T_HZ_NS, CLK_NS);
    localparam int C_WC  = ns_to_cycles(T_WC_NS, CLK_NS);
    localparam int C_WP  = ns_to_cycles(T_WP_NS, CLK_NS);
    localparam int C_CW  = ns_to_cycles(T_CW_NS, CLK_NS);
    localparam int C_DW  = ns_to_cycles(T_DW_NS, CLK_NS);

    localparam int RD_LEN = max2(C_RC, C_AA);
    localparam int W_DRV  = max2(max2(C_DW, C_WP - C_HZ), max2(C_CW - C_HZ, 1));
    localparam int W_LOW  = C_HZ + W_DRV;
    localparam int W_LEN  = max2(W_LOW + 1, C_WC);
    localparam int CNT_W  = $clog2(max2(RD_LEN, W_LEN) + 1);

    ctl_state_e       st_d;
    logic [CNT_W-1:0] cnt_d;
    logic             accept;
    logic             capture;

    sram_ctrl_seq #(
        .CNT_W   (CNT_W),
        .RD_LAST (RD_LEN - 1),
        .AA_IDX  (C_AA - 1),
        .W_LAST  (W_LEN - 1)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .wr      (wr),
        .st_d_o  (st_d),
        .cnt_d_o (cnt_d),
        .accept  (accept),
        .capture (capture),
        .ack     (ack)
    );

    sram_ctrl_strobe #(
        .CNT_W  (CNT_W),
        .HZ_GAP (C_HZ),
        .W_LOW  (W_LOW)
    ) u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .st_d  (st_d),
        .cnt_d (cnt_d),
        .ce_n  (sram_ce_n),
        .we_n  (sram_we_n),
        .oe_n  (sram_oe_n),
        .drv   (sram_dq_oe)
    );

    sram_ctrl_dpath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .capture  (capture),
        .addr     (addr),
        .wdata    (wdata),
        .dq_in    (sram_dq_in),
        .mem_addr (sram_addr),
        .dq_out   (sram_dq_out),
        .rdata    (rdata)
    );

endmodule

// File: rtl/sram_timing_ctrl_chk.sv
module sram_timing_ctrl_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              sram_dq_oe
);

    // R10
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> !(!sram_ce_n && !sram_oe_n));

    // R5
    oe_high_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_oe_n && !sram_ce_n));

    // R9
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R9
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    // R7
    drive_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> sram_dq_oe);

    // R7
    drive_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we_n && $past(sram_we_n) && !$past(sram_ce_n)) |-> !sram_dq_oe);

endmodule

bind sram_timing_ctrl sram_timing_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack        (ack),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/tb_sram_timing_ctrl.sv
module tb_sram_timing_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ack;
    logic [7:0]  rdata;
    logic [14:0] sram_addr;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in = '0;
    logic        sram_dq_oe, sram_ce_n, sram_we_n, sram_oe_n;

    always #5 clk = ~clk;

    sram_timing_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
        .ack(ack), .rdata(rdata), .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
        .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe), .sram_ce_n(sram_ce_n),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
    );

    // Expected values taken from the requirements at a 10 ns clock.
    localparam int RD_CYC  = 7;
    localparam int AA_CYC  = 7;
    localparam int GAP_CYC = 3;
    localparam int WLO_CYC = 6;
    localparam int SET_CYC = 3;

    typedef struct {
        logic [4:0]  pins;   // {ce_n, we_n, oe_n, dq_oe, ack}
        string       tag;
        bit          chk_a;
        logic [14:0] a;
        bit          chk_rd;
        logic [7:0]  rd;
    } exp_t;

    exp_t        eq[$];
    logic [7:0]  exp_mem[int];
    logic [7:0]  mem[int];
    int          checks = 0;
    int          errors = 0;
    int          rd_cnt = 0;
    int          float_cnt = 100;
    int          wlow = 0;
    int          dset = 0;
    logic [7:0]  last_d = '0;
    logic [14:0] last_a = '0;
    logic [14:0] prev_addr = '0;
    bit          last_was_ack = 0;

    function automatic logic [7:0] rd_mem(input int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    function automatic logic [7:0] rd_exp(input int a);
        return exp_mem.exists(a) ? exp_mem[a] : 8'h00;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t mk(input logic [4:0] p, input string t,
                                input logic [14:0] a, input bit ca);
        exp_t e;
        e.pins = p; e.tag = t; e.a = a; e.chk_a = ca; e.chk_rd = 0; e.rd = '0;
        return e;
    endfunction

    task automatic push_seq(input logic w, input logic [14:0] a, input logic [7:0] d,
                            input bit b2b);
        exp_t e;
        if (!w) begin
            for (int i = 0; i < RD_CYC; i++)
                eq.push_back(mk(5'b01000, (i == 0 && b2b) ? "R11" : "R3", a, 1));
            e = mk(5'b11101, "R9", a, 0);
            e.chk_rd = 1; e.rd = rd_exp(a);
            eq.push_back(e);
        end else begin
            for (int i = 0; i < GAP_CYC; i++)
                eq.push_back(mk(5'b00100, (i == 0 && b2b) ? "R11" : "R6", a, 1));
            for (int i = 0; i < WLO_CYC - GAP_CYC; i++)
                eq.push_back(mk(5'b00110, "R5", a, 1));
            eq.push_back(mk(5'b01110, "R7", a, 1));
            eq.push_back(mk(5'b11101, "R9", a, 0));
            exp_mem[a] = d;
        end
    endtask

    // One cycle: compare at the falling edge, then update the memory model.
    task automatic next_cycle();
        exp_t       e;
        logic [4:0] got;
        bit         on;
        @(negedge clk);
        got = {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, ack};
        if (eq.size() != 0) e = eq.pop_front();
        else e = mk(5'b11100, "R1", '0, 0);
        last_was_ack = e.pins[0];
        check(got == e.pins, e.tag, "pins", got, e.pins);
        if (e.chk_a) check(sram_addr == e.a, e.tag, "address", sram_addr, e.a);
        if (e.chk_rd) check(rdata == e.rd, "R4", "rdata", rdata, e.rd);

        on = !sram_ce_n && !sram_oe_n && sram_we_n;
        float_cnt = on ? 0 : ((float_cnt < 100) ? float_cnt + 1 : 100);
        if (sram_dq_oe)
            check(float_cnt > GAP_CYC, "R10", "drive during float", float_cnt, GAP_CYC + 1);

        if (!sram_ce_n && !sram_we_n) begin
            wlow++;
            if (sram_dq_oe) begin
                dset = (dset != 0 && sram_dq_out != last_d) ? 1 : dset + 1;
                last_d = sram_dq_out;
            end
            last_a = sram_addr;
        end else if (wlow != 0) begin
            check(wlow >= WLO_CYC, "R5", "we low cycles", wlow, WLO_CYC);
            check(dset >= SET_CYC, "R7", "data setup cycles", dset, SET_CYC);
            mem[last_a] = last_d;
            wlow = 0; dset = 0;
        end

        if (on) rd_cnt = (rd_cnt != 0 && sram_addr == prev_addr) ? rd_cnt + 1 : 1;
        else rd_cnt = 0;
        prev_addr = sram_addr;
        sram_dq_in = (rd_cnt >= AA_CYC) ? rd_mem(sram_addr) : ~rd_mem(sram_addr);
    endtask

    task automatic issue(input logic w, input logic [14:0] a, input logic [7:0] d);
        while (eq.size() != 0) begin
            req = 1'b0;
            next_cycle();
        end
        req = 1'b1; wr = w; addr = a; wdata = d;
        push_seq(w, a, d, last_was_ack);
        next_cycle();
        req = 1'b0;
    endtask

    task automatic drain();
        while (eq.size() != 0) next_cycle();
        next_cycle();
    endtask

    initial begin
        fork
            begin : main
                repeat (3) @(negedge clk);
                // R1 reset state
                check({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, ack} == 5'b11100,
                      "R1", "reset pins",
                      {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, ack}, 5'b11100);
                rst_n = 1'b1;
                repeat (2) next_cycle();

                // R8 writes at both ends of the address range, back to back
                issue(1'b1, 15'h0000, 8'hA5);
                issue(1'b1, 15'h7FFF, 8'h3C);
                issue(1'b1, 15'h1234, 8'h5A);
                drain();
                // R4 reads back, write-to-read and read-to-read back to back (R11)
                issue(1'b0, 15'h0000, 8'h00);
                // R2 stray request while a read is running
                req = 1'b1; wr = 1'b1; addr = 15'h0F0F; wdata = 8'hFF;
                next_cycle();
                req = 1'b0;
                issue(1'b0, 15'h7FFF, 8'h00);
                issue(1'b0, 15'h1234, 8'h00);
                issue(1'b1, 15'h1234, 8'hC3);
                issue(1'b0, 15'h1234, 8'h00);
                issue(1'b0, 15'h0F0F, 8'h00);
                // R2 stray request during a write
                issue(1'b1, 15'h2222, 8'h81);
                req = 1'b1; wr = 1'b0; addr = 15'h5555; wdata = 8'h00;
                next_cycle();
                req = 1'b0;
                drain();
                repeat (4) next_cycle();
                issue(1'b0, 15'h2222, 8'h00);
                issue(1'b0, 15'h0F0F, 8'h00);
                for (int i = 0; i < 6; i++) issue(1'b1, 15'(16'h0100 + i * 37), 8'(i * 29 + 7));
                for (int i = 0; i < 6; i++) issue(1'b0, 15'(16'h0100 + i * 37), 8'h00);
                drain();
                repeat (3) next_cycle();
            end
            begin : watchdog
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL R1 watchdog: actual running expected finished");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule